// File: doc/BRIEF.md
# Dual-Ring Register Mailbox

This block links a host processor to an embedded engine through two one-way rings of 32-bit slots. Each side has one ring that it fills and the other side drains. Both sides see the same small register window. A word written to the write window is pushed onto the writer's own ring. A read of the read window pops the oldest word from the other side's ring. Each ring is described by a status word. That word holds an 8-bit producer pointer and an 8-bit consumer pointer that count accesses and wrap at 256, plus the ring size in slots. Software takes the fill level as the 8-bit difference of the two pointers, and the free space as the size minus that level.

The status word also carries the control bits. These are an interrupt enable, an interrupt flag, a doorbell bit that raises the other side's interrupt flag, a ready flag, a reset request and a sticky error flag. A side resets the link by setting its reset request together with the doorbell. It then waits until the other side shows ready again, and finally clears the request. While its request is set, that side's ring pointers are held at zero.

Top module: `mbox_top`

## Requirements
- R1: Each side decodes a 2-bit word index. Index 0 is the write window, index 1 is the side's own status word, index 2 is the read window and index 3 is the other side's status word (byte offsets 0x00, 0x04, 0x08 and 0x0C). A read of index 0 returns 0. A write to index 2 or 3 changes nothing.
- R2: The status word layout is: bit 0 interrupt enable, bit 1 interrupt flag, bit 2 doorbell (always reads 0), bit 3 ready, bit 4 reset request, bit 5 error, bits 7:6 zero, bits 15:8 consumer pointer, bits 23:16 producer pointer, bits 31:24 ring size. After hardware reset every field is 0 except the size.
- R3: A write to the write window stores one 32-bit slot and advances the writer's producer pointer by 1. Reads of the other side's read window return the slots in the order written, and each read advances the consumer pointer by 1.
- R4: Both pointers wrap from 255 to 0. The 8-bit difference (producer − consumer) always equals the number of stored slots and never exceeds the ring size. Data order is kept across the wrap, including for a ring size that is not a power of two.
- R5: A write when the ring holds as many slots as its size is dropped. No pointer moves, no stored slot changes, and the writer's error bit is set.
- R6: A read of an empty read window returns 0, moves no pointer and sets the reader's error bit. The error bit stays set until its owner writes 1 to bit 5 of its own status word.
- R7: Writing 1 to the doorbell bit sets the other side's interrupt flag, which is visible once that write completes.
- R8: Writing 1 to bit 1 clears the writer's own interrupt flag. If a doorbell from the other side arrives in the same cycle, the flag stays set.
- R9: A side's interrupt output is high exactly when its interrupt enable and interrupt flag are both 1.
- R10: While a side's reset request is set, its producer and consumer pointers read 0, its ready bit reads 0 even if written as 1, and its write-window writes are dropped.
- R11: A write that raises a side's reset request clears the other side's ready bit. The other side may then set ready again, and normal traffic resumes once the request is cleared.
- R12: Read data appears on the side's read-data output one clock after the access and holds until that side's next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 2 | Host word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| host_irq | output | 1 | Host interrupt |
| eng_sel | input | 1 | Engine access strobe |
| eng_we | input | 1 | Engine access is a write |
| eng_addr | input | 2 | Engine word index |
| eng_wdata | input | 32 | Engine write data |
| eng_rdata | output | 32 | Engine read data, registered |
| eng_irq | output | 1 | Engine interrupt |

## Verification
A corrupted pointer or slot index shows up at the ports in two ways. The next status read returns a wrong pointer field, and the next read-window access returns a word out of order. The bench therefore compares every popped word and checks the status word after each batch, so a fault is caught within one batch of five slots. A lost or stuck control bit shows on the interrupt output or in the next status read, one access after the event. Batches of five slots carry the pointers across the 255-to-0 wrap, so a fault in the wrap or in the modulo-size indexing appears as soon as the wrap is crossed.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef logic [7:0] ptr_t;

    typedef enum logic [1:0] {
        WIN_WR   = 2'd0,
        STAT_OWN = 2'd1,
        WIN_RD   = 2'd2,
        STAT_FAR = 2'd3
    } reg_sel_e;

    localparam int unsigned B_IE  = 0;
    localparam int unsigned B_IS  = 1;
    localparam int unsigned B_IG  = 2;
    localparam int unsigned B_RDY = 3;
    localparam int unsigned B_RST = 4;
    localparam int unsigned B_ERR = 5;

    typedef struct packed {
        logic        ie;
        logic        is;
        logic        rdy;
        logic        rst;
        logic        err;
        logic [31:0] rdata;
    } side_st_t;

    function automatic logic [31:0] pack_status(input ptr_t size, input ptr_t wp,
                                                input ptr_t rp, input logic err,
                                                input logic rst, input logic rdy,
                                                input logic is, input logic ie);
        return {size, wp, rp, 2'b00, err, rst, rdy, 1'b0, is, ie};
    endfunction

endpackage

// File: rtl/mbox_ring.sv
module mbox_ring
    import mbox_pkg::*;
#(
    parameter int unsigned DEPTH  = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output ptr_t              wp,
    output ptr_t              rp,
    output logic              full,
    output logic              empty
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam ptr_t        SIZE  = ptr_t'(DEPTH);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        ptr_t             wp;
        ptr_t             rp;
        logic [IDX_W-1:0] widx;
        logic [IDX_W-1:0] ridx;
    } ring_st_t;

    ring_st_t s_d, s_q;
    logic [DATA_W-1:0] mem [DEPTH];
    ptr_t fill;
    logic do_push, do_pop;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] i);
        return (i == LAST) ? '0 : i + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        fill    = s_q.wp - s_q.rp;
        full    = (fill == SIZE);
        empty   = (fill == 8'd0);
        do_push = push && !full && !clr;
        do_pop  = pop && !empty && !clr;
        if (clr) begin
            s_d = '0;
        end else begin
            if (do_push) begin
                s_d.wp   = s_q.wp + 8'd1;
                s_d.widx = bump(s_q.widx);
            end
            if (do_pop) begin
                s_d.rp   = s_q.rp + 8'd1;
                s_d.ridx = bump(s_q.ridx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.widx] <= push_data;
    end

    assign head_data = mem[s_q.ridx];
    assign wp        = s_q.wp;
    assign rp        = s_q.rp;

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= SIZE);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr) |=> $stable(s_q.wp));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !clr) |=> $stable(s_q.rp));

    // R10
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.wp == 8'd0 && s_q.rp == 8'd0));

endmodule

// File: rtl/mbox_side.sv
module mbox_side
    import mbox_pkg::*;
#(
    parameter int unsigned DEPTH = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  logic        we,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    input  ptr_t        own_wp,
    input  ptr_t        own_rp,
    input  logic        own_full,
    input  logic [31:0] far_head,
    input  logic        far_empty,
    input  logic [31:0] far_status,
    input  logic        far_ig,
    input  logic        far_rst_rise,
    output logic [31:0] status,
    output logic        push,
    output logic        pop,
    output logic        clr,
    output logic        ig_pulse,
    output logic        rst_rise
);

    localparam ptr_t SIZE = ptr_t'(DEPTH);

    side_st_t s_d, s_q;
    reg_sel_e rsel;
    logic     wr, rd, csr_wr;

    assign status = pack_status(SIZE, own_wp, own_rp, s_q.err, s_q.rst,
                                s_q.rdy, s_q.is, s_q.ie);

    always_comb begin
        rsel     = reg_sel_e'(addr);
        wr       = sel && we;
        rd       = sel && !we;
        csr_wr   = wr && (rsel == STAT_OWN);
        push     = wr && (rsel == WIN_WR);
        pop      = rd && (rsel == WIN_RD);
        ig_pulse = csr_wr && wdata[B_IG];
        rst_rise = csr_wr && wdata[B_RST] && !s_q.rst;
        s_d      = s_q;

        if (csr_wr) begin
            s_d.ie  = wdata[B_IE];
            s_d.rst = wdata[B_RST];
            s_d.rdy = wdata[B_RDY];
            if (wdata[B_IS])  s_d.is  = 1'b0;
            if (wdata[B_ERR]) s_d.err = 1'b0;
        end
        if (far_ig) s_d.is = 1'b1;
        if (push && own_full && !s_d.rst) s_d.err = 1'b1;
        if (pop && far_empty) s_d.err = 1'b1;
        if (far_rst_rise || s_d.rst) s_d.rdy = 1'b0;

        if (rd) begin
            unique case (rsel)
                WIN_WR:   s_d.rdata = 32'd0;
                STAT_OWN: s_d.rdata = status;
                WIN_RD:   s_d.rdata = far_empty ? 32'd0 : far_head;
                STAT_FAR: s_d.rdata = far_status;
                default:  s_d.rdata = 32'd0;
            endcase
        end
        clr = s_d.rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.rdata;
    assign irq   = s_q.ie && s_q.is;

    // R7
    ig_sets_is_chk: assert property (@(posedge clk) disable iff (!rst_n)
        far_ig |=> s_q.is);

    // R10
    rdy_low_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rst |-> !s_q.rdy);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err && !(csr_wr && wdata[B_ERR])) |=> s_q.err);

    // R11
    far_rst_drops_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        far_rst_rise |=> !s_q.rdy);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/mbox_top.sv
module mbox_top
    import mbox_pkg::*;
#(
    parameter int unsigned DEPTH = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_sel,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        host_irq,
    input  logic        eng_sel,
    input  logic        eng_we,
    input  logic [1:0]  eng_addr,
    input  logic [31:0] eng_wdata,
    output logic [31:0] eng_rdata,
    output logic        eng_irq
);

    localparam int unsigned NSIDE = 2;

    logic        sel    [NSIDE];
    logic        we     [NSIDE];
    logic [1:0]  addr   [NSIDE];
    logic [31:0] wdata  [NSIDE];
    logic [31:0] rdata  [NSIDE];
    logic        irq    [NSIDE];
    logic [31:0] status [NSIDE];
    logic [31:0] head   [NSIDE];
    ptr_t        wp     [NSIDE];
    ptr_t        rp     [NSIDE];
    logic        full   [NSIDE];
    logic        empty  [NSIDE];
    logic        push   [NSIDE];
    logic        pop    [NSIDE];
    logic        clr    [NSIDE];
    logic        ig     [NSIDE];
    logic        rrise  [NSIDE];

    assign sel[0]   = host_sel;
    assign we[0]    = host_we;
    assign addr[0]  = host_addr;
    assign wdata[0] = host_wdata;
    assign sel[1]   = eng_sel;
    assign we[1]    = eng_we;
    assign addr[1]  = eng_addr;
    assign wdata[1] = eng_wdata;
    assign host_rdata = rdata[0];
    assign host_irq   = irq[0];
    assign eng_rdata  = rdata[1];
    assign eng_irq    = irq[1];

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        localparam int F = NSIDE - 1 - g;

        mbox_ring #(.DEPTH(DEPTH), .DATA_W(32)) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr[g]),
            .push      (push[g]),
            .push_data (wdata[g]),
            .pop       (pop[F]),
            .head_data (head[g]),
            .wp        (wp[g]),
            .rp        (rp[g]),
            .full      (full[g]),
            .empty     (empty[g])
        );

        mbox_side #(.DEPTH(DEPTH)) u_side (
            .clk          (clk),
            .rst_n        (rst_n),
            .sel          (sel[g]),
            .we           (we[g]),
            .addr         (addr[g]),
            .wdata        (wdata[g]),
            .rdata        (rdata[g]),
            .irq          (irq[g]),
            .own_wp       (wp[g]),
            .own_rp       (rp[g]),
            .own_full     (full[g]),
            .far_head     (head[F]),
            .far_empty    (empty[F]),
            .far_status   (status[F]),
            .far_ig       (ig[F]),
            .far_rst_rise (rrise[F]),
            .status       (status[g]),
            .push         (push[g]),
            .pop          (pop[g]),
            .clr          (clr[g]),
            .ig_pulse     (ig[g]),
            .rst_rise     (rrise[g])
        );
    end

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> status[0][B_IE]);

endmodule

// File: tb/mbox_top_tb.sv
module mbox_top_tb;

    localparam int unsigned DEPTH = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0, hwe = 1'b0, esel = 1'b0, ewe = 1'b0;
    logic [1:0]  haddr = '0, eaddr = '0;
    logic [31:0] hwd = '0, ewd = '0;
    logic [31:0] hrd, erd;
    logic        hirq, eirq;
    int          nchk = 0, nerr = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    mbox_top #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_sel(hsel), .host_we(hwe), .host_addr(haddr), .host_wdata(hwd),
        .host_rdata(hrd), .host_irq(hirq),
        .eng_sel(esel), .eng_we(ewe), .eng_addr(eaddr), .eng_wdata(ewd),
        .eng_rdata(erd), .eng_irq(eirq)
    );

    typedef struct packed {
        logic        side;
        logic        we;
        logic [1:0]  idx;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 2'd1, 32'h0C00_0000},  // R2 reset value, host
        '{1'b1, 1'b0, 2'd1, 32'h0C00_0000},  // R2 reset value, engine
        '{1'b0, 1'b1, 2'd0, 32'h1111_1111},
        '{1'b0, 1'b1, 2'd0, 32'h2222_2222},
        '{1'b0, 1'b1, 2'd0, 32'h3333_3333},
        '{1'b0, 1'b0, 2'd1, 32'h0C03_0000},  // R3 producer moved
        '{1'b1, 1'b0, 2'd3, 32'h0C03_0000},  // R1 mirrored status
        '{1'b1, 1'b0, 2'd2, 32'h1111_1111},  // R3 order
        '{1'b1, 1'b0, 2'd2, 32'h2222_2222},
        '{1'b0, 1'b0, 2'd1, 32'h0C03_0200},  // R4 fill by difference
        '{1'b1, 1'b1, 2'd0, 32'hA5A5_A5A5},
        '{1'b0, 1'b0, 2'd3, 32'h0C01_0000},
        '{1'b0, 1'b0, 2'd2, 32'hA5A5_A5A5},
        '{1'b1, 1'b0, 2'd2, 32'h3333_3333},
        '{1'b0, 1'b0, 2'd0, 32'h0000_0000},  // R1 write window reads 0
        '{1'b0, 1'b0, 2'd1, 32'h0C03_0300},
        '{1'b0, 1'b1, 2'd2, 32'hDEAD_BEEF},  // R1 write to read window
        '{1'b0, 1'b0, 2'd3, 32'h0C01_0100}   // R1 nothing changed
    };

    function automatic logic [31:0] stw(input logic [7:0] w, input logic [7:0] r,
                                        input logic [5:0] fl);
        return {8'(DEPTH), w, r, 2'b00, fl};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic side, input logic w, input logic [1:0] idx,
                       input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        if (side) begin esel = 1'b1; ewe = w; eaddr = idx; ewd = wd; end
        else      begin hsel = 1'b1; hwe = w; haddr = idx; hwd = wd; end
        @(negedge clk);
        hsel = 1'b0; hwe = 1'b0; esel = 1'b0; ewe = 1'b0;
        rd = side ? erd : hrd;
    endtask

    task automatic wr(input logic side, input logic [1:0] idx, input logic [31:0] wd);
        logic [31:0] dummy;
        acc(side, 1'b1, idx, wd, dummy);
    endtask

    task automatic rdchk(input logic side, input logic [1:0] idx, input logic [31:0] exp,
                         input string req);
        logic [31:0] v;
        acc(side, 1'b0, idx, 32'd0, v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  base;
        repeat (3) @(negedge clk);
        check("R2 reset host_rdata", hrd, 32'd0);
        check("R9 reset irqs", {30'd0, hirq, eirq}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i].side, VEC[i].we, VEC[i].idx, VEC[i].data, v);
            if (!VEC[i].we) check($sformatf("R1 R3 R4 vector %0d", i), v, VEC[i].data);
        end

        // R12: previous data holds until the next read completes
        @(negedge clk);
        hsel = 1'b1; hwe = 1'b0; haddr = 2'd1;
        #1 check("R12 old data before edge", hrd, 32'h0C01_0100);
        @(negedge clk);
        hsel = 1'b0;
        check("R12 new data after edge", hrd, 32'h0C03_0300);

        // R5: fill host ring, then overflow
        for (int i = 0; i < DEPTH; i++) wr(1'b0, 2'd0, 32'h100 + i);
        rdchk(1'b0, 2'd1, stw(8'd15, 8'd3, 6'h00), "R5 full status");
        wr(1'b0, 2'd0, 32'h0BAD);
        rdchk(1'b0, 2'd1, stw(8'd15, 8'd3, 6'h20), "R5 overflow ignored, error set");
        for (int i = 0; i < DEPTH; i++)
            rdchk(1'b1, 2'd2, 32'h100 + i, "R5 stored slots intact");
        // R6: underflow
        rdchk(1'b1, 2'd2, 32'd0, "R6 empty read returns 0");
        rdchk(1'b1, 2'd1, stw(8'd1, 8'd1, 6'h20), "R6 engine error set");
        rdchk(1'b1, 2'd1, stw(8'd1, 8'd1, 6'h20), "R6 error sticky");
        wr(1'b1, 2'd1, 32'h20);
        wr(1'b0, 2'd1, 32'h20);
        rdchk(1'b1, 2'd1, stw(8'd1, 8'd1, 6'h00), "R6 engine error cleared");
        rdchk(1'b0, 2'd1, stw(8'd15, 8'd15, 6'h00), "R6 host error cleared");

        // R4: batches across the pointer wrap
        base = 8'd15;
        for (int k = 0; k < 60; k++) begin
            for (int j = 0; j < 5; j++) wr(1'b0, 2'd0, {16'hC0DE, 8'(k), 8'(j)});
            rdchk(1'b1, 2'd3, stw(base + 8'd5, base, 6'h00), "R4 fill across wrap");
            for (int j = 0; j < 5; j++)
                rdchk(1'b1, 2'd2, {16'hC0DE, 8'(k), 8'(j)}, "R4 order across wrap");
            base = base + 8'd5;
        end
        rdchk(1'b0, 2'd1, stw(8'd59, 8'd59, 6'h00), "R4 wrapped pointers");

        // R7 R8 R9
        wr(1'b0, 2'd1, 32'h1);
        check("R9 enable alone no irq", {31'd0, hirq}, 32'd0);
        wr(1'b1, 2'd1, 32'h4);
        check("R7 doorbell raises host irq", {31'd0, hirq}, 32'd1);
        rdchk(1'b0, 2'd1, stw(8'd59, 8'd59, 6'h03), "R7 host flag set");
        rdchk(1'b1, 2'd1, stw(8'd1, 8'd1, 6'h00), "R2 doorbell reads 0");
        wr(1'b0, 2'd1, 32'h3);
        check("R8 flag cleared", {31'd0, hirq}, 32'd0);
        @(negedge clk);
        hsel = 1'b1; hwe = 1'b1; haddr = 2'd1; hwd = 32'h3;
        esel = 1'b1; ewe = 1'b1; eaddr = 2'd1; ewd = 32'h4;
        @(negedge clk);
        hsel = 1'b0; hwe = 1'b0; esel = 1'b0; ewe = 1'b0;
        check("R8 set wins over clear", {31'd0, hirq}, 32'd1);
        wr(1'b0, 2'd1, 32'h0);
        check("R9 disabled masks irq", {31'd0, hirq}, 32'd0);
        rdchk(1'b0, 2'd1, stw(8'd59, 8'd59, 6'h02), "R9 flag kept while masked");
        wr(1'b0, 2'd1, 32'h2);

        // R10 R11: reset handshake
        wr(1'b1, 2'd1, 32'h8);
        rdchk(1'b1, 2'd1, stw(8'd1, 8'd1, 6'h08), "R11 engine ready");
        wr(1'b0, 2'd0, 32'h55);
        wr(1'b0, 2'd0, 32'h66);
        wr(1'b0, 2'd1, 32'h14);
        rdchk(1'b0, 2'd1, stw(8'd0, 8'd0, 6'h10), "R10 pointers zero in reset");
        rdchk(1'b1, 2'd1, stw(8'd1, 8'd1, 6'h02), "R11 far ready dropped, flag set");
        wr(1'b0, 2'd0, 32'h99);
        rdchk(1'b0, 2'd1, stw(8'd0, 8'd0, 6'h10), "R10 write ignored in reset");
        rdchk(1'b1, 2'd2, 32'd0, "R10 nothing readable");
        wr(1'b1, 2'd1, 32'h2A);
        rdchk(1'b1, 2'd1, stw(8'd1, 8'd1, 6'h08), "R11 engine ready again");
        wr(1'b0, 2'd1, 32'h18);
        rdchk(1'b0, 2'd1, stw(8'd0, 8'd0, 6'h10), "R10 ready held low");
        wr(1'b0, 2'd1, 32'h08);
        rdchk(1'b0, 2'd1, stw(8'd0, 8'd0, 6'h08), "R11 reset released");
        wr(1'b0, 2'd0, 32'h77);
        rdchk(1'b1, 2'd2, 32'h77, "R11 traffic resumes");
        rdchk(1'b0, 2'd1, stw(8'd1, 8'd1, 6'h08), "R3 pointers after resume");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule